// File: doc/BRIEF.md
# Bit-Serial BCH Syndrome Generator

This block computes the full set of 2t syndromes of a received binary BCH codeword over GF(2^M). Words of 16 bits enter through a valid/ready handshake. A small serializer splits each word into sixteen single bits. The syndrome core takes one bit per clock, so it needs only one constant multiplier and one XOR per odd syndrome. This gives a gate count far below a word-parallel core. The price is that the core must run sixteen times as fast per bit as the word rate.

For every odd index j, an accumulator follows Horner's rule: S_j <= S_j * alpha^j + r. The received bits enter highest degree first. The even syndromes are not accumulated. They are formed by squaring, since S_2j = (S_j)^2. When the last bit of a record has been absorbed, the block registers all syndromes and issues a one-cycle strobe. It also raises a flag when every syndrome is zero, which means no error was detected. An abort input returns the block to its reset state without using reset.

Top module: `bch_syndrome_gen`

## Requirements
- R1: After reset, `syn_vld_o`, `syn_zero_o` and `syn_o` are all zero, and `word_rdy_o` is 1.
- R2: A record is REC_WORDS words of 16 bits, which is N = 16*REC_WORDS bits. The first bit received is the coefficient of degree N-1, and each word is sent bit 15 first. For each odd k, the field `syn_o[(k-1)*M +: M]` equals r(alpha^k). Field elements use the polynomial basis, with alpha = 2.
- R3: For each even k, the field `syn_o[(k-1)*M +: M]` equals the square of the field for k/2.
- R4: `syn_vld_o` is high for exactly one cycle, 16 cycles after the edge that accepts the last word of a record. `syn_o` then holds its value until the next result or an abort.
- R5: `syn_zero_o` is updated together with `syn_vld_o`. It is 1 exactly when all 2t syndromes are zero.
- R6: A word is accepted on an edge where `word_vld_i` and `word_rdy_o` are both high. `word_rdy_o` is low from the edge after an acceptance until the word has one bit left to send. Words offered while it is low are ignored. Back-to-back words keep the core fed without gaps.
- R7: Idle cycles between words pause the core. They do not change the result.
- R8: A cycle with `abort_i` high clears any partial record and the output registers. It leaves `word_rdy_o` at 1 and `syn_vld_o` at 0. The next record is computed from scratch.
- R9: The accumulators clear at the end of each record, so consecutive records, including back-to-back ones, produce independent results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Synchronous abort, returns the block to its reset state |
| word_vld_i | input | 1 | Input word valid |
| word_i | input | 16 | Input word, bit 15 sent first |
| word_rdy_o | output | 1 | Serializer can take a word |
| syn_vld_o | output | 1 | One-cycle strobe: syndromes are ready |
| syn_zero_o | output | 1 | All syndromes zero |
| syn_o | output | 2*T*M | Syndromes S1..S2t, S_k at bits (k-1)*M +: M |

## Verification
A word accepted at edge E is absorbed over edges E+1 to E+16. The result of a record is therefore registered at the sixteenth edge after its last acceptance. It is visible from the following falling edge. The bench drives words and samples outputs on falling edges. For one record it counts exactly fifteen falling edges after the final acceptance, expects the strobe to be low there, and expects it high one falling edge later. For all other records, a monitor pairs each strobe with the next expected item in a queue. It also flags any strobe that arrives with no record pending. Reference syndromes are computed by summing powers of alpha from a table built in the bench.

// File: rtl/bchsyn_pkg.sv
package bchsyn_pkg;

    localparam int WORD_W = 16;
    localparam int GF_MAXW = 16;

    typedef struct packed {
        logic vld;
        logic val;
    } ser_bit_t;

    // GF(2^m) multiply, polynomial basis, m <= 16
    function automatic logic [GF_MAXW-1:0] gf_mul(input logic [GF_MAXW-1:0] a,
                                                  input logic [GF_MAXW-1:0] b,
                                                  input int m,
                                                  input logic [GF_MAXW:0] poly);
        logic [GF_MAXW:0] r;
        r = '0;
        for (int i = GF_MAXW - 1; i >= 0; i--) begin
            if (i < m) begin
                r = r << 1;
                if (r[m]) r = r ^ poly;
                if (b[i]) r = r ^ {1'b0, a};
            end
        end
        return r[GF_MAXW-1:0];
    endfunction

    function automatic logic [GF_MAXW-1:0] gf_alpha_pow(input int j, input int m,
                                                        input logic [GF_MAXW:0] poly);
        logic [GF_MAXW-1:0] r;
        r = 1;
        for (int i = 0; i < j; i++) r = gf_mul(r, 2, m, poly);
        return r;
    endfunction

endpackage

// File: rtl/bchsyn_ser.sv
module bchsyn_ser
    import bchsyn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_i,
    input  logic              word_vld_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              word_rdy_o,
    output ser_bit_t          bit_o
);
    localparam int CNTW = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sh;
    logic [CNTW-1:0]   cnt;

    assign word_rdy_o = (cnt <= CNTW'(1));
    assign bit_o.vld  = (cnt != '0);
    assign bit_o.val  = sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            sh  <= '0;
            cnt <= '0;
        end else if (word_vld_i && word_rdy_o) begin
            sh  <= word_i;
            cnt <= CNTW'(WORD_W);
        end else if (cnt != '0) begin
            sh  <= sh << 1;
            cnt <= cnt - CNTW'(1);
        end
    end
endmodule

// File: rtl/bchsyn_odd_cell.sv
module bchsyn_odd_cell
    import bchsyn_pkg::*;
#(
    parameter int              M    = 8,
    parameter logic [GF_MAXW:0] POLY = 17'h11D,
    parameter int              J    = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_in,
    output logic [M-1:0] nxt
);
    localparam logic [GF_MAXW-1:0] AJ = gf_alpha_pow(J, M, POLY);

    logic [M-1:0]         acc;
    logic [GF_MAXW-1:0]   prod;

    assign prod = gf_mul(GF_MAXW'(acc), AJ, M, POLY);
    assign nxt  = prod[M-1:0] ^ M'(bit_in);

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc <= '0;
        else if (en)
            acc <= nxt;
    end
endmodule

// File: rtl/bch_syndrome_gen.sv
module bch_syndrome_gen
    import bchsyn_pkg::*;
#(
    parameter int               M         = 8,
    parameter int               T         = 4,
    parameter logic [GF_MAXW:0] POLY      = 17'h11D,
    parameter int               REC_WORDS = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 abort_i,
    input  logic                 word_vld_i,
    input  logic [WORD_W-1:0]    word_i,
    output logic                 word_rdy_o,
    output logic                 syn_vld_o,
    output logic                 syn_zero_o,
    output logic [2*T*M-1:0]     syn_o
);
    localparam int NBITS = REC_WORDS * WORD_W;
    localparam int CW    = $clog2(NBITS);
    localparam int NSYN  = 2 * T;

    ser_bit_t              sb;
    logic [CW-1:0]         bcnt;
    logic                  last;
    logic [T-1:0][M-1:0]   odd_nxt;
    logic [NSYN:1][M-1:0]  full;
    logic [NSYN-1:0][M-1:0] syn_q;
    logic                  vld_q;
    logic                  zero_q;

    bchsyn_ser u_ser (
        .clk        (clk),
        .rst        (rst),
        .abort_i    (abort_i),
        .word_vld_i (word_vld_i),
        .word_i     (word_i),
        .word_rdy_o (word_rdy_o),
        .bit_o      (sb)
    );

    assign last = sb.vld && (bcnt == CW'(NBITS - 1));

    always_ff @(posedge clk) begin
        if (rst || abort_i)
            bcnt <= '0;
        else if (sb.vld)
            bcnt <= last ? '0 : bcnt + CW'(1);
    end

    for (genvar i = 0; i < T; i++) begin : g_odd
        bchsyn_odd_cell #(.M(M), .POLY(POLY), .J(2 * i + 1)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .clr    (abort_i || last),
            .en     (sb.vld),
            .bit_in (sb.val),
            .nxt    (odd_nxt[i])
        );
    end

    for (genvar k = 1; k <= NSYN; k++) begin : g_full
        if (k % 2 == 1) begin : g_o
            assign full[k] = odd_nxt[(k - 1) / 2];
        end else begin : g_e
            logic [GF_MAXW-1:0] sq;
            assign sq      = gf_mul(GF_MAXW'(full[k/2]), GF_MAXW'(full[k/2]), M, POLY);
            assign full[k] = sq[M-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            syn_q  <= '0;
            vld_q  <= 1'b0;
            zero_q <= 1'b0;
        end else begin
            vld_q <= last;
            if (last) begin
                syn_q  <= full;
                zero_q <= (full == '0);
            end
        end
    end

    assign syn_o      = syn_q;
    assign syn_vld_o  = vld_q;
    assign syn_zero_o = zero_q;
endmodule

// File: rtl/bchsyn_chk.sv
module bchsyn_chk
    import bchsyn_pkg::*;
#(
    parameter int               M    = 8,
    parameter int               T    = 4,
    parameter logic [GF_MAXW:0] POLY = 17'h11D
) (
    input logic             clk,
    input logic             rst,
    input logic             abort_i,
    input logic             word_vld_i,
    input logic             word_rdy_o,
    input logic             syn_vld_o,
    input logic             syn_zero_o,
    input logic [2*T*M-1:0] syn_o
);
    logic [GF_MAXW-1:0] s1sq;
    assign s1sq = gf_mul(GF_MAXW'(syn_o[M-1:0]), GF_MAXW'(syn_o[M-1:0]), M, POLY);

    // R3: second syndrome is the square of the first
    p_even_sq_r3: assert property (@(posedge clk) disable iff (rst)
        syn_vld_o |-> syn_o[2*M-1:M] == s1sq[M-1:0]);

    // R4: strobe lasts one cycle
    p_vld_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        syn_vld_o |=> !syn_vld_o);

    // R4: result held between strobes unless aborted
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !abort_i |=> syn_vld_o || $stable(syn_o));

    // R5: zero flag agrees with bus when strobed
    p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
        syn_vld_o |-> syn_zero_o == (syn_o == '0));

    // R6: an accepted word makes the serializer busy
    p_busy_r6: assert property (@(posedge clk) disable iff (rst)
        word_vld_i && word_rdy_o && !abort_i |=> !word_rdy_o);

    // R8: abort returns outputs to idle
    p_abort_r8: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !syn_vld_o && !syn_zero_o && syn_o == '0 && word_rdy_o);
endmodule

bind bch_syndrome_gen bchsyn_chk #(.M(M), .T(T), .POLY(POLY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .abort_i    (abort_i),
    .word_vld_i (word_vld_i),
    .word_rdy_o (word_rdy_o),
    .syn_vld_o  (syn_vld_o),
    .syn_zero_o (syn_zero_o),
    .syn_o      (syn_o)
);

// File: tb/sim_bch_syndrome_gen.sv
module sim_bch_syndrome_gen;
    localparam int M = 8;
    localparam int T = 4;
    localparam logic [16:0] POLY = 17'h11D;
    localparam int REC_WORDS = 15;
    localparam int N = REC_WORDS * 16;
    localparam int ORD = 255;
    localparam int SW = 2 * T * M;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic abort_i = 1'b0;
    logic word_vld_i = 1'b0;
    logic [15:0] word_i = '0;
    logic word_rdy_o, syn_vld_o, syn_zero_o;
    logic [SW-1:0] syn_o;

    always #10 clk = ~clk;

    bch_syndrome_gen #(.M(M), .T(T), .POLY(POLY), .REC_WORDS(REC_WORDS)) u0 (
        .clk(clk), .rst(rst), .abort_i(abort_i), .word_vld_i(word_vld_i),
        .word_i(word_i), .word_rdy_o(word_rdy_o), .syn_vld_o(syn_vld_o),
        .syn_zero_o(syn_zero_o), .syn_o(syn_o));

    typedef struct {
        logic [SW-1:0] syn;
        logic          zero;
    } exp_t;

    exp_t q[$];
    exp_t last_exp;
    int n_chk = 0, n_fail = 0;
    logic [7:0] expt [0:ORD-1];
    logic [15:0] rec [REC_WORDS];
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [SW-1:0] act, input logic [SW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // reference: S_k = XOR of alpha^(k*d) over set degrees d
    function automatic exp_t ref_syn();
        exp_t e;
        e.syn = '0;
        for (int w = 0; w < REC_WORDS; w++)
            for (int b = 15; b >= 0; b--)
                if (rec[w][b]) begin
                    int d;
                    d = N - 1 - (16 * w + (15 - b));
                    for (int k = 1; k <= 2 * T; k++)
                        e.syn[(k-1)*M +: M] ^= expt[(k * d) % ORD];
                end
        e.zero = (e.syn == '0);
        return e;
    endfunction

    task automatic set_deg(input int d);
        rec[(N - 1 - d) / 16][15 - ((N - 1 - d) % 16)] ^= 1'b1;
    endtask

    task automatic clear_rec();
        for (int w = 0; w < REC_WORDS; w++) rec[w] = '0;
    endtask

    task automatic drive_word(input logic [15:0] w);
        word_vld_i = 1'b1;
        word_i = w;
        while (!word_rdy_o) @(negedge clk);
        @(negedge clk);
        word_vld_i = 1'b0;
        word_i = $urandom;
    endtask

    // gap_max: idle cycles between words (0 = back-to-back)
    task automatic send_rec(input bit push, input int gap_max, input int nwords);
        if (push) q.push_back(ref_syn());
        for (int w = 0; w < nwords; w++) begin
            drive_word(rec[w]);
            if (gap_max > 0) repeat ($urandom_range(0, gap_max)) @(negedge clk);
        end
    endtask

    // monitor: pop and compare at each strobe
    always @(negedge clk) begin
        if (!rst && syn_vld_o) begin
            if (q.size() == 0) begin
                chk(1'b0, "R4", "unexpected strobe", syn_o, '0);
            end else begin
                exp_t e;
                bit odd_ok, even_ok;
                e = q.pop_front();
                last_exp = e;
                odd_ok = 1; even_ok = 1;
                for (int k = 1; k <= 2 * T; k++)
                    if (syn_o[(k-1)*M +: M] !== e.syn[(k-1)*M +: M]) begin
                        if (k % 2) odd_ok = 0; else even_ok = 0;
                    end
                chk(odd_ok, "R2", "odd syndromes", syn_o, e.syn);
                chk(even_ok, "R3", "even syndromes", syn_o, e.syn);
                chk(syn_zero_o === e.zero, "R5", "zero flag", SW'(syn_zero_o), SW'(e.zero));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R4", "watchdog expired", '0, '0);
            summary();
        end
    end

    task automatic wait_empty();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        expt[0] = 8'h01;
        for (int i = 1; i < ORD; i++)
            expt[i] = expt[i-1][7] ? ((expt[i-1] << 1) ^ POLY[7:0]) : (expt[i-1] << 1);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(syn_vld_o === 1'b0 && syn_zero_o === 1'b0, "R1", "flags after reset",
            SW'({syn_vld_o, syn_zero_o}), '0);
        chk(syn_o === '0, "R1", "syndromes after reset", syn_o, '0);
        chk(word_rdy_o === 1'b1, "R1", "ready after reset", SW'(word_rdy_o), SW'(1));

        // R5 all-zero record, with exact strobe timing (R4)
        clear_rec();
        q.push_back(ref_syn());
        for (int w = 0; w < REC_WORDS; w++) drive_word(rec[w]);
        repeat (15) @(negedge clk);
        chk(syn_vld_o === 1'b0, "R4", "strobe not yet at 15", SW'(syn_vld_o), '0);
        @(negedge clk);
        chk(syn_vld_o === 1'b1, "R4", "strobe at 16", SW'(syn_vld_o), SW'(1));
        @(negedge clk);
        chk(syn_vld_o === 1'b0, "R4", "strobe one cycle", SW'(syn_vld_o), '0);

        // R2 single errors at the extreme degrees, gaps between words (R7)
        clear_rec(); set_deg(N - 1); send_rec(1, 3, REC_WORDS); wait_empty();
        clear_rec(); set_deg(0);     send_rec(1, 3, REC_WORDS); wait_empty();

        // R4 hold: outputs stay after strobe
        repeat (25) @(negedge clk);
        chk(syn_o === last_exp.syn, "R4", "held after strobe", syn_o, last_exp.syn);

        // R2/R3 up to T random errors, back-to-back records (R9)
        for (int r = 0; r < 4; r++) begin
            clear_rec();
            for (int e = 0; e < T; e++) set_deg($urandom_range(0, N - 1));
            send_rec(1, 0, REC_WORDS);
        end
        wait_empty();

        // random data, random pauses (R7)
        for (int r = 0; r < 4; r++) begin
            for (int w = 0; w < REC_WORDS; w++) rec[w] = $urandom;
            send_rec(1, (r % 2) ? 5 : 0, REC_WORDS);
        end
        wait_empty();

        // R6 words offered while busy are ignored
        for (int w = 0; w < REC_WORDS; w++) rec[w] = $urandom;
        q.push_back(ref_syn());
        for (int w = 0; w < REC_WORDS; w++) begin
            drive_word(rec[w]);
            if (w == 3) begin
                word_vld_i = 1'b1;
                word_i = ~rec[w + 1];
                repeat (5) begin
                    chk(word_rdy_o === 1'b0, "R6", "ready low while busy", SW'(word_rdy_o), '0);
                    @(negedge clk);
                end
                word_vld_i = 1'b0;
            end
        end
        wait_empty();

        // R8 abort mid record
        for (int w = 0; w < REC_WORDS; w++) rec[w] = $urandom;
        send_rec(0, 0, 5);
        repeat (3) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(syn_o === '0 && syn_vld_o === 1'b0 && syn_zero_o === 1'b0, "R8",
            "outputs cleared by abort", syn_o, '0);
        chk(word_rdy_o === 1'b1, "R8", "ready after abort", SW'(word_rdy_o), SW'(1));
        clear_rec(); set_deg(100); set_deg(7);
        send_rec(1, 0, REC_WORDS);
        wait_empty();
        repeat (20) @(negedge clk);
        chk(syn_vld_o === 1'b0 && q.size() == 0, "R8", "no stray result", SW'(syn_vld_o), '0);

        done = 1;
        summary();
    end
endmodule